// File: doc/BRIEF.md
# Read/Write Bus Turnaround Controller

This block decides, one scheduling cycle at a time, whether a memory controller's shared data bus serves reads or writes. It watches the total number of pending reads and pending writes, a drain request, and the strobes that mark a burst being issued. From these it keeps a two-state direction machine with the states RD_TURN and WR_TURN. It also raises a one-cycle flag when the direction has just flipped, so that the command scheduler can add turnaround delay to the next command, and it keeps a count of the bursts served in the current turn.

Writes are batched by two write-queue watermarks with hysteresis. While in RD_TURN, the machine stays with reads until the read queue runs dry, or until a read issues while the write backlog is above the high watermark. While in WR_TURN, it keeps writing until the write queue is empty, or until the backlog is well below the low watermark, or until a minimum batch of writes has been done while reads are waiting. A drain request pushes writes out even when the backlog is below the low watermark. The watermarks and the minimum batch are static parameters, and the low watermark must be below the high one.

The machine has four transitions. RD_TO_WR fires when the read queue is empty and writes qualify, or when a read issues under write pressure. WR_TO_RD fires when the write queue is empty, when the backlog is low, or when the minimum batch is met with reads waiting. RD_HOLD and WR_HOLD cover every other case. A decision taken in cycle t becomes the current direction after the next rising clock edge.

Top module: `bus_turn_ctrl`

## Requirements
- R1: After reset, dir_wr is 0 (RD_TURN), turn_switched is 0 and turn_bursts is 0.
- R2: In RD_TURN with rd_pending equal to 0, the controller moves to WR_TURN if wr_pending is nonzero and either drain_req is 1 or wr_pending is greater than WM_LO. Otherwise it stays in RD_TURN.
- R3: In RD_TURN with rd_pending nonzero, the controller moves to WR_TURN only in a cycle where rd_issue is 1 and wr_pending is greater than WM_HI. Otherwise it stays in RD_TURN.
- R4: In WR_TURN with wr_pending equal to 0, the controller returns to RD_TURN, whatever the other inputs are.
- R5: In WR_TURN, in a cycle where wr_issue is 1 and drain_req is 0, the controller returns to RD_TURN if wr_pending + MIN_WR is less than WM_LO. While drain_req is 1, this rule does not apply.
- R6: In WR_TURN, in a cycle where wr_issue is 1 and rd_pending is nonzero, the controller returns to RD_TURN if the writes of this turn, counting the one issued in that cycle, are at least MIN_WR. With wr_pending nonzero and no wr_issue, it stays in WR_TURN.
- R7: dir_wr encodes the direction as 0 for RD_TURN and 1 for WR_TURN. A decision taken from the inputs of cycle t shows on dir_wr after the next rising edge of clk.
- R8: turn_switched is 1 in exactly those cycles whose direction differs from the direction of the previous cycle, and 0 in all other cycles.
- R9: turn_bursts increases by one for each rd_issue in RD_TURN and for each wr_issue in WR_TURN. A strobe for the other direction is ignored. The count saturates at 2^BURST_W - 1.
- R10: In the first cycle of a new turn, turn_bursts is 0, even when an issue strobe was present in the cycle that decided the switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one scheduling cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_pending | input | QCNT_W | Total number of reads waiting |
| wr_pending | input | QCNT_W | Total number of writes waiting |
| drain_req | input | 1 | Request to flush the write backlog |
| rd_issue | input | 1 | A read burst is issued this cycle |
| wr_issue | input | 1 | A write burst is issued this cycle |
| dir_wr | output | 1 | Current bus direction: 0 means read, 1 means write |
| turn_switched | output | 1 | The direction changed at the last edge |
| turn_bursts | output | BURST_W | Bursts served in the current turn |

## Verification
The main overlap is a burst issue and a direction switch that fall in the same cycle. The issue strobe asks the burst counter to increment, while the switch decision clears it. This case is provoked by raising rd_issue together with a write backlog above WM_HI, and by raising wr_issue on the write that completes the minimum batch. It is judged by checking that the new turn opens with a zero count and the switch flag raised. A second overlap is a pair of switches on consecutive edges (write queue empties just after a drain-forced switch), where turn_switched must stay high across both cycles.

// File: rtl/bus_turn_pkg.sv
package bus_turn_pkg;

    typedef enum logic [0:0] {
        RD_TURN = 1'b0,
        WR_TURN = 1'b1
    } turn_dir_e;

endpackage

// File: rtl/turn_rd_policy.sv
module turn_rd_policy #(
    parameter int QCNT_W = 6,
    parameter int WM_HI  = 20,
    parameter int WM_LO  = 8
) (
    input  logic [QCNT_W-1:0] rd_pending,
    input  logic [QCNT_W-1:0] wr_pending,
    input  logic              drain_req,
    input  logic              rd_issue,
    output logic              go_write
);
    logic rd_empty;
    logic wr_any;
    logic over_lo;
    logic over_hi;

    always_comb begin
        rd_empty = (rd_pending == '0);
        wr_any   = (wr_pending != '0);
        over_lo  = (int'(wr_pending) > WM_LO);
        over_hi  = (int'(wr_pending) > WM_HI);
        if (rd_empty) begin
            // idle read side: flush writes if enough or drain forced
            go_write = wr_any && (drain_req || over_lo);
        end else begin
            // reads pending: only a read issue under pressure flips
            go_write = rd_issue && over_hi;
        end
    end
endmodule

// File: rtl/turn_wr_policy.sv
module turn_wr_policy #(
    parameter int QCNT_W  = 6,
    parameter int BURST_W = 5,
    parameter int WM_LO   = 8,
    parameter int MIN_WR  = 4
) (
    input  logic [QCNT_W-1:0]  rd_pending,
    input  logic [QCNT_W-1:0]  wr_pending,
    input  logic               drain_req,
    input  logic               wr_issue,
    input  logic [BURST_W-1:0] writes_done,
    output logic               go_read
);
    logic wr_empty;
    logic backlog_low;
    logic batch_met;

    always_comb begin
        wr_empty    = (wr_pending == '0);
        backlog_low = ((int'(wr_pending) + MIN_WR) < WM_LO) && !drain_req;
        // batch size includes the write issued in this very cycle
        batch_met   = (rd_pending != '0) && ((int'(writes_done) + 1) >= MIN_WR);
        go_read     = wr_empty || (wr_issue && (backlog_low || batch_met));
    end
endmodule

// File: rtl/turn_burst_counter.sv
module turn_burst_counter #(
    parameter int BURST_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               inc,
    output logic [BURST_W-1:0] cnt
);
    localparam logic [BURST_W-1:0] CNT_MAX = {BURST_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/bus_turn_ctrl.sv
module bus_turn_ctrl
    import bus_turn_pkg::*;
#(
    parameter int QCNT_W  = 6,
    parameter int BURST_W = 5,
    parameter int WM_HI   = 20,
    parameter int WM_LO   = 8,
    parameter int MIN_WR  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [QCNT_W-1:0]  rd_pending,
    input  logic [QCNT_W-1:0]  wr_pending,
    input  logic               drain_req,
    input  logic               rd_issue,
    input  logic               wr_issue,
    output logic               dir_wr,
    output logic               turn_switched,
    output logic [BURST_W-1:0] turn_bursts
);
    turn_dir_e state_q;
    turn_dir_e state_d;
    logic      sw_q;
    logic      go_write;
    logic      go_read;
    logic      cnt_clear;
    logic      cnt_inc;

    turn_rd_policy #(
        .QCNT_W (QCNT_W),
        .WM_HI  (WM_HI),
        .WM_LO  (WM_LO)
    ) rd_pol_i (
        .rd_pending (rd_pending),
        .wr_pending (wr_pending),
        .drain_req  (drain_req),
        .rd_issue   (rd_issue),
        .go_write   (go_write)
    );

    turn_wr_policy #(
        .QCNT_W  (QCNT_W),
        .BURST_W (BURST_W),
        .WM_LO   (WM_LO),
        .MIN_WR  (MIN_WR)
    ) wr_pol_i (
        .rd_pending  (rd_pending),
        .wr_pending  (wr_pending),
        .drain_req   (drain_req),
        .wr_issue    (wr_issue),
        .writes_done (turn_bursts),
        .go_read     (go_read)
    );

    // next-direction decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_TURN: if (go_write) state_d = WR_TURN;
            WR_TURN: if (go_read)  state_d = RD_TURN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_TURN;
            sw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            sw_q    <= (state_d != state_q);
        end
    end

    // outputs and counter control
    always_comb begin
        dir_wr        = (state_q == WR_TURN);
        turn_switched = sw_q;
        cnt_clear     = (state_d != state_q);
        cnt_inc       = 1'b0;
        unique case (state_q)
            RD_TURN: cnt_inc = rd_issue;
            WR_TURN: cnt_inc = wr_issue;
        endcase
    end

    turn_burst_counter #(
        .BURST_W (BURST_W)
    ) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .cnt   (turn_bursts)
    );

    // R2
    rd_idle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_wr && rd_pending == '0 && wr_pending != '0 &&
         (drain_req || int'(wr_pending) > WM_LO)) |=> dir_wr);

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_wr && rd_pending != '0 && !rd_issue) |=> !dir_wr);

    // R3
    hi_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_wr && rd_pending != '0 && rd_issue && int'(wr_pending) > WM_HI) |=> dir_wr);

    // R4
    wr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && wr_pending == '0) |=> !dir_wr);

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && wr_pending != '0 && !wr_issue) |=> dir_wr);

    // R8
    switch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_switched |-> (dir_wr != $past(dir_wr)));

    // R10
    fresh_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_switched |-> (turn_bursts == '0));
endmodule

// File: tb/bus_turn_ctrl_tb.sv
module bus_turn_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QCNT_W  = 6;
    localparam int BURST_W = 5;
    localparam int WM_HI   = 20;
    localparam int WM_LO   = 8;
    localparam int MIN_WR  = 4;
    localparam int NVEC    = 19;

    // {rd[25:20], wr[19:14], drain[13], ri[12], wi[11],
    //  exp_dir[10], exp_sw[9], exp_cnt[8:4], req[3:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {6'd3, 6'd5,  1'b0,1'b1,1'b0, 1'b0,1'b0,5'd1, 4'd9},  // R9 read counted
        {6'd3, 6'd5,  1'b0,1'b0,1'b1, 1'b0,1'b0,5'd1, 4'd9},  // R9 write strobe ignored
        {6'd2, 6'd21, 1'b0,1'b0,1'b0, 1'b0,1'b0,5'd1, 4'd3},  // R3 no issue, hold
        {6'd2, 6'd21, 1'b0,1'b1,1'b0, 1'b1,1'b1,5'd0, 4'd10}, // R10 switch with issue
        {6'd2, 6'd20, 1'b0,1'b1,1'b0, 1'b1,1'b0,5'd0, 4'd6},  // R6 no wr issue, hold
        {6'd2, 6'd19, 1'b0,1'b0,1'b1, 1'b1,1'b0,5'd1, 4'd6},
        {6'd2, 6'd18, 1'b0,1'b0,1'b1, 1'b1,1'b0,5'd2, 4'd6},
        {6'd2, 6'd17, 1'b0,1'b0,1'b1, 1'b1,1'b0,5'd3, 4'd6},
        {6'd2, 6'd16, 1'b0,1'b0,1'b1, 1'b0,1'b1,5'd0, 4'd6},  // R6 batch met
        {6'd0, 6'd8,  1'b0,1'b0,1'b0, 1'b0,1'b0,5'd0, 4'd2},  // R2 at low mark, hold
        {6'd0, 6'd9,  1'b0,1'b0,1'b0, 1'b1,1'b1,5'd0, 4'd2},  // R2 above low mark
        {6'd0, 6'd3,  1'b1,1'b0,1'b1, 1'b1,1'b0,5'd1, 4'd5},  // R5 drain blocks
        {6'd0, 6'd3,  1'b0,1'b0,1'b1, 1'b0,1'b1,5'd0, 4'd5},  // R5 backlog low
        {6'd0, 6'd2,  1'b1,1'b0,1'b0, 1'b1,1'b1,5'd0, 4'd2},  // R2 drain forces
        {6'd0, 6'd0,  1'b0,1'b0,1'b0, 1'b0,1'b1,5'd0, 4'd8},  // R8 back-to-back switch
        {6'd0, 6'd0,  1'b1,1'b0,1'b0, 1'b0,1'b0,5'd0, 4'd2},  // R2 nothing to flush
        {6'd1, 6'd30, 1'b0,1'b0,1'b0, 1'b0,1'b0,5'd0, 4'd3},
        {6'd1, 6'd30, 1'b0,1'b1,1'b0, 1'b1,1'b1,5'd0, 4'd7},  // R7 one-edge latency
        {6'd1, 6'd0,  1'b0,1'b0,1'b1, 1'b0,1'b1,5'd0, 4'd4}   // R4 empty writes
    };

    logic               clk;
    logic               rst_n;
    logic [QCNT_W-1:0]  rd_pending;
    logic [QCNT_W-1:0]  wr_pending;
    logic               drain_req;
    logic               rd_issue;
    logic               wr_issue;
    logic               dir_wr;
    logic               turn_switched;
    logic [BURST_W-1:0] turn_bursts;

    int n_checks;
    int n_fails;
    bit finished;

    bus_turn_ctrl #(
        .QCNT_W  (QCNT_W),
        .BURST_W (BURST_W),
        .WM_HI   (WM_HI),
        .WM_LO   (WM_LO),
        .MIN_WR  (MIN_WR)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_pending    (rd_pending),
        .wr_pending    (wr_pending),
        .drain_req     (drain_req),
        .rd_issue      (rd_issue),
        .wr_issue      (wr_issue),
        .dir_wr        (dir_wr),
        .turn_switched (turn_switched),
        .turn_bursts   (turn_bursts)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_name(input int r);
        case (r)
            1: return "R1";  2: return "R2";  3: return "R3";
            4: return "R4";  5: return "R5";  6: return "R6";
            7: return "R7";  8: return "R8";  9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int rd, input int wr, input bit dr, input bit ri, input bit wi);
        rd_pending = QCNT_W'(rd);
        wr_pending = QCNT_W'(wr);
        drain_req  = dr;
        rd_issue   = ri;
        wr_issue   = wi;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(0, 0, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        finished = 0;
        do_reset();
        // R1 reset state
        check("R1", int'(dir_wr), 0, "dir after reset");
        check("R1", int'(turn_switched), 0, "switched after reset");
        check("R1", int'(turn_bursts), 0, "bursts after reset");

        for (int i = 0; i < NVEC; i++) begin
            logic [25:0] v;
            v = VEC[i];
            drive(int'(v[25:20]), int'(v[19:14]), v[13], v[12], v[11]);
            @(negedge clk);
            check(req_name(int'(v[3:0])), int'(dir_wr), int'(v[10]), $sformatf("dir row %0d", i));
            check(req_name(int'(v[3:0])), int'(turn_switched), int'(v[9]), $sformatf("switched row %0d", i));
            check(req_name(int'(v[3:0])), int'(turn_bursts), int'(v[8:4]), $sformatf("bursts row %0d", i));
        end

        // R9 saturation: many reads with no write pressure
        do_reset();
        for (int k = 0; k < 40; k++) begin
            drive(5, 0, 1'b0, 1'b1, 1'b0);
            @(negedge clk);
        end
        check("R9", int'(turn_bursts), 31, "saturated count");
        check("R9", int'(dir_wr), 0, "still reading");

        // R7 decision visible only after the edge
        drive(0, 12, 1'b0, 1'b0, 1'b0);
        #1;
        check("R7", int'(dir_wr), 0, "no change before edge");
        @(negedge clk);
        check("R7", int'(dir_wr), 1, "change after edge");
        check("R10", int'(turn_bursts), 0, "fresh write turn");

        // R1 reset mid-run returns to read
        do_reset();
        check("R1", int'(dir_wr), 0, "dir after second reset");
        check("R1", int'(turn_bursts), 0, "bursts after second reset");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule